// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the 13-bit fetch address of a processor with an 8K-word program space. It updates that address from one of several commands: step to the next word, branch using an 11-bit literal, load from a software write to the visible low byte, or restore a full address supplied by an external return-address store. The upper five address bits are never loaded directly. They come from a separate 5-bit page register that software writes on its own port.

A branch literal covers only a 2K-word window. The two top address bits come from the two upper bits of the page register, so a branch stays inside the current window unless software rewrites that register first. A write to the low byte takes all five page bits for the top of the address. A return ignores the page register and takes all 13 bits from outside. On a call, the block presents the address that follows the calling word, with a one-cycle strobe, for an external store to save. Neither calls nor returns change the page register.

Top module: `paged_pc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `fetch_addr`, `page_q`, `link_addr` and `link_push` all become 0 after that edge.
- R2: With only `step_en` asserted, `fetch_addr` becomes the old value plus one after the edge, and 1FFFh wraps to 0000h.
- R3: A branch (`br_en`) loads `fetch_addr` with {`page_q`[4:3], `br_lit`[10:0]}, using the page value held before that edge.
- R4: A low-byte write (`low_we`) loads `fetch_addr` with {`page_q`[4:0], `low_data`[7:0]}, using the page value held before that edge, even when `page_we` is asserted in the same cycle.
- R5: A return (`ret_en`) loads `fetch_addr` with all 13 bits of `ret_addr`, whatever the page register holds.
- R6: When several commands are active together, the order from highest to lowest is reset, return, branch, low-byte write, step.
- R7: A branch with `br_call` high, when not overridden by return, sets `link_push` to 1 for exactly the following cycle and sets `link_addr` to the old `fetch_addr` plus one (1FFFh wraps to 0). A branch with `br_call` low, or any other command, leaves `link_push` at 0.
- R8: `page_we` loads `page_q` from `page_data` at the edge. Without `page_we`, `page_q` holds its value through calls and returns.
- R9: With no command active, `fetch_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| page_we | input | 1 | Write strobe for the page register |
| page_data | input | 5 | New page register value |
| step_en | input | 1 | Advance to the next word |
| br_en | input | 1 | Branch using the 11-bit literal |
| br_call | input | 1 | Marks the branch as a call |
| br_lit | input | 11 | Branch literal |
| low_we | input | 1 | Software write to the low address byte |
| low_data | input | 8 | Data for the low-byte write |
| ret_en | input | 1 | Load the full return address |
| ret_addr | input | 13 | Address restored on a return |
| fetch_addr | output | 13 | Registered fetch address |
| page_q | output | 5 | Registered page register value |
| link_push | output | 1 | One-cycle strobe: save `link_addr` |
| link_addr | output | 13 | Address following the calling word |

## Verification
Each internal register drives an output directly, so any wrong state appears at the ports on the first rising edge after the faulty update. A wrong page value is hidden until the next branch or low-byte write, so the stimulus always follows a page write with one of those commands. A priority fault shows only when commands overlap, so the stimulus asserts overlapping commands deliberately. A wrong link value shows in the same cycle as `link_push`.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD = 3'd0,
    SEL_STEP = 3'd1,
    SEL_LOW  = 3'd2,
    SEL_BR   = 3'd3,
    SEL_RET  = 3'd4
  } pc_sel_e;
endpackage

// File: rtl/pcu_cmd_arbiter.sv
module pcu_cmd_arbiter
  import pcu_pkg::*;
(
  input  logic    ret_en,
  input  logic    br_en,
  input  logic    low_we,
  input  logic    step_en,
  output pc_sel_e sel
);
  always_comb begin
    if (ret_en)       sel = SEL_RET;
    else if (br_en)   sel = SEL_BR;
    else if (low_we)  sel = SEL_LOW;
    else if (step_en) sel = SEL_STEP;
    else              sel = SEL_HOLD;
  end
endmodule

// File: rtl/pcu_next_calc.sv
module pcu_next_calc
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LIT_W  = 11,
  parameter int LOW_W  = 8
) (
  input  pc_sel_e                    sel,
  input  logic [ADDR_W-1:0]          cur_pc,
  input  logic [ADDR_W-LOW_W-1:0]    page,
  input  logic [LIT_W-1:0]           lit,
  input  logic [LOW_W-1:0]           low_data,
  input  logic [ADDR_W-1:0]          ret_addr,
  output logic [ADDR_W-1:0]          next_pc,
  output logic [ADDR_W-1:0]          inc_pc
);
  localparam int HIGH_W = ADDR_W - LOW_W;
  localparam int SEL_W  = ADDR_W - LIT_W;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [SEL_W-1:0] page_sel;

  assign page_sel = page[HIGH_W-1 -: SEL_W];
  assign inc_pc   = cur_pc + ONE;

  always_comb begin
    unique case (sel)
      SEL_RET:  next_pc = ret_addr;
      SEL_BR:   next_pc = {page_sel, lit};
      SEL_LOW:  next_pc = {page, low_data};
      SEL_STEP: next_pc = inc_pc;
      default:  next_pc = cur_pc;
    endcase
  end
endmodule

// File: rtl/pcu_page_reg.sv
module pcu_page_reg #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/pcu_link_reg.sv
module pcu_link_reg #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_now,
  input  logic [ADDR_W-1:0] inc_pc,
  output logic              push,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      push <= 1'b0;
      addr <= '0;
    end else begin
      push <= call_now;
      if (call_now) addr <= inc_pc;
    end
  end
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LIT_W  = 11,
  parameter int LOW_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       page_we,
  input  logic [ADDR_W-LOW_W-1:0]    page_data,
  input  logic                       step_en,
  input  logic                       br_en,
  input  logic                       br_call,
  input  logic [LIT_W-1:0]           br_lit,
  input  logic                       low_we,
  input  logic [LOW_W-1:0]           low_data,
  input  logic                       ret_en,
  input  logic [ADDR_W-1:0]          ret_addr,
  output logic [ADDR_W-1:0]          fetch_addr,
  output logic [ADDR_W-LOW_W-1:0]    page_q,
  output logic                       link_push,
  output logic [ADDR_W-1:0]          link_addr
);
  localparam int HIGH_W = ADDR_W - LOW_W;

  pc_sel_e           sel;
  logic [ADDR_W-1:0] next_pc;
  logic [ADDR_W-1:0] inc_pc;
  logic              call_now;

  pcu_cmd_arbiter u_arb (
    .ret_en (ret_en),
    .br_en  (br_en),
    .low_we (low_we),
    .step_en(step_en),
    .sel    (sel)
  );

  pcu_next_calc #(.ADDR_W(ADDR_W), .LIT_W(LIT_W), .LOW_W(LOW_W)) u_next (
    .sel     (sel),
    .cur_pc  (fetch_addr),
    .page    (page_q),
    .lit     (br_lit),
    .low_data(low_data),
    .ret_addr(ret_addr),
    .next_pc (next_pc),
    .inc_pc  (inc_pc)
  );

  pcu_page_reg #(.WIDTH(HIGH_W)) u_page (
    .clk  (clk),
    .rst  (rst),
    .we   (page_we),
    .wdata(page_data),
    .q    (page_q)
  );

  assign call_now = (sel == SEL_BR) && br_call;

  pcu_link_reg #(.ADDR_W(ADDR_W)) u_link (
    .clk     (clk),
    .rst     (rst),
    .call_now(call_now),
    .inc_pc  (inc_pc),
    .push    (link_push),
    .addr    (link_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) fetch_addr <= '0;
    else     fetch_addr <= next_pc;
  end
endmodule

// File: rtl/paged_pc_unit_chk.sv
module paged_pc_unit_chk #(
  parameter int ADDR_W = 13,
  parameter int LIT_W  = 11,
  parameter int LOW_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    page_we,
  input logic [ADDR_W-LOW_W-1:0] page_data,
  input logic                    step_en,
  input logic                    br_en,
  input logic                    br_call,
  input logic [LIT_W-1:0]        br_lit,
  input logic                    low_we,
  input logic [LOW_W-1:0]        low_data,
  input logic                    ret_en,
  input logic [ADDR_W-1:0]       ret_addr,
  input logic [ADDR_W-1:0]       fetch_addr,
  input logic [ADDR_W-LOW_W-1:0] page_q,
  input logic                    link_push,
  input logic [ADDR_W-1:0]       link_addr
);
  localparam int HIGH_W = ADDR_W - LOW_W;
  localparam int SEL_W  = ADDR_W - LIT_W;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (fetch_addr == '0 && page_q == '0 && !link_push && link_addr == '0)); // R1

  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (rst)
    (step_en && !ret_en && !br_en && !low_we) |=> fetch_addr == $past(fetch_addr) + ONE); // R2

  AST_BRANCH_PAGE: assert property (@(posedge clk) disable iff (rst)
    (br_en && !ret_en) |=> fetch_addr == {$past(page_q[HIGH_W-1 -: SEL_W]), $past(br_lit)}); // R3

  AST_LOW_WRITE: assert property (@(posedge clk) disable iff (rst)
    (low_we && !ret_en && !br_en) |=> fetch_addr == {$past(page_q), $past(low_data)}); // R4

  AST_RETURN_FULL: assert property (@(posedge clk) disable iff (rst)
    ret_en |=> fetch_addr == $past(ret_addr)); // R5

  AST_CALL_LINK: assert property (@(posedge clk) disable iff (rst)
    (br_en && br_call && !ret_en) |=> (link_push && link_addr == $past(fetch_addr) + ONE)); // R7

  AST_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    !(br_en && br_call && !ret_en) |=> !link_push); // R7

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !page_we |=> $stable(page_q)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(step_en || br_en || low_we || ret_en) |=> $stable(fetch_addr)); // R9
endmodule

bind paged_pc_unit paged_pc_unit_chk #(.ADDR_W(ADDR_W), .LIT_W(LIT_W), .LOW_W(LOW_W)) chk_i (
  .clk(clk), .rst(rst), .page_we(page_we), .page_data(page_data),
  .step_en(step_en), .br_en(br_en), .br_call(br_call), .br_lit(br_lit),
  .low_we(low_we), .low_data(low_data), .ret_en(ret_en), .ret_addr(ret_addr),
  .fetch_addr(fetch_addr), .page_q(page_q), .link_push(link_push), .link_addr(link_addr)
);

// File: tb/paged_pc_unit_tb_top.sv
`timescale 1ns/1ps
module paged_pc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        page_we;
  logic [4:0]  page_data;
  logic        step_en, br_en, br_call, low_we, ret_en;
  logic [10:0] br_lit;
  logic [7:0]  low_data;
  logic [12:0] ret_addr;
  logic [12:0] fetch_addr, link_addr;
  logic [4:0]  page_q;
  logic        link_push;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int m_pc = 0, m_page = 0, m_link = 0, m_push = 0;

  always #2.5 clk = ~clk;

  paged_pc_unit dut_i (
    .clk(clk), .rst(rst), .page_we(page_we), .page_data(page_data),
    .step_en(step_en), .br_en(br_en), .br_call(br_call), .br_lit(br_lit),
    .low_we(low_we), .low_data(low_data), .ret_en(ret_en), .ret_addr(ret_addr),
    .fetch_addr(fetch_addr), .page_q(page_q), .link_push(link_push), .link_addr(link_addr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    page_we = 0; page_data = 0; step_en = 0; br_en = 0; br_call = 0;
    br_lit = 0; low_we = 0; low_data = 0; ret_en = 0; ret_addr = 0;
  endtask

  // Apply inputs (already set), advance one clock, update model, compare.
  task automatic tick(input string req);
    int old_pc, old_page;
    @(posedge clk);
    old_pc = m_pc; old_page = m_page;
    if (rst) begin
      m_pc = 0; m_page = 0; m_link = 0; m_push = 0;
    end else begin
      m_push = 0;
      if (ret_en) m_pc = int'(ret_addr);
      else if (br_en) begin
        m_pc = ((old_page / 8) * 2048) + int'(br_lit);
        if (br_call) begin
          m_push = 1;
          m_link = (old_pc + 1) % 8192;
        end
      end
      else if (low_we) m_pc = (old_page * 256) + int'(low_data);
      else if (step_en) m_pc = (old_pc + 1) % 8192;
      if (page_we) m_page = int'(page_data);
    end
    @(negedge clk);
    chk(req, "fetch_addr", int'(fetch_addr), m_pc);
    chk(req, "page_q", int'(page_q), m_page);
    chk(req, "link_push", int'(link_push), m_push);
    chk(req, "link_addr", int'(link_addr), m_link);
    idle();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    idle();
    rst = 1;
    @(negedge clk);
    // R1: reset with commands active must still clear everything
    step_en = 1; page_we = 1; page_data = 5'h1F;
    tick("R1");
    tick("R1");
    rst = 0;
    // R9: idle hold
    tick("R9");
    // R2: steps
    for (int i = 0; i < 3; i++) begin step_en = 1; tick("R2"); end
    // R8: page write
    page_we = 1; page_data = 5'h0A; tick("R8");
    // R3: branch within page 1
    br_en = 1; br_lit = 11'h123; tick("R3");
    // R7: call from 0x923
    br_en = 1; br_call = 1; br_lit = 11'h7FF; tick("R7");
    tick("R7");
    // R7: plain branch leaves push low
    br_en = 1; br_lit = 11'h001; tick("R7");
    // R4: low write uses full page
    low_we = 1; low_data = 8'h5C; tick("R4");
    // R4: same-cycle page write uses old page
    low_we = 1; low_data = 8'h11; page_we = 1; page_data = 5'h15; tick("R4");
    low_we = 1; low_data = 8'h22; tick("R4");
    // R5: return ignores page, R8 page stays
    ret_en = 1; ret_addr = 13'h0ABC; tick("R5");
    ret_en = 1; ret_addr = 13'h1FFF; tick("R5");
    // R2 wrap via step
    step_en = 1; tick("R2");
    // R2 wrap via low write to 1FFF then step
    page_we = 1; page_data = 5'h1F; tick("R8");
    low_we = 1; low_data = 8'hFF; tick("R4");
    // R7 call at 1FFF wraps link address
    br_en = 1; br_call = 1; br_lit = 11'h400; tick("R7");
    low_we = 1; low_data = 8'hFF; tick("R4");
    step_en = 1; tick("R2");
    // R6: priority combinations
    ret_en = 1; ret_addr = 13'h0333; br_en = 1; br_call = 1; br_lit = 11'h055;
    low_we = 1; low_data = 8'h77; step_en = 1; tick("R6");
    br_en = 1; br_lit = 11'h066; low_we = 1; low_data = 8'h88; step_en = 1; tick("R6");
    low_we = 1; low_data = 8'h99; step_en = 1; tick("R6");
    page_we = 1; page_data = 5'h08; br_en = 1; br_lit = 11'h010; tick("R6");
    br_en = 1; br_lit = 11'h020; tick("R3");
    // R1: reset mid-run with a call pending
    rst = 1; br_en = 1; br_call = 1; tick("R1");
    rst = 0; tick("R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule